// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Bank

This block holds one interrupt flag and one mask bit for each message buffer of a message controller. When the protocol engine completes a transmit or a receive on a buffer, it sends a one-cycle pulse on that buffer's event line. The pulse sets the buffer's flag. A buffer requests service while its flag and its mask bit are both one. The combined request line is the OR over all buffers, delayed by one register.

Software reaches the block through a single-cycle register port. A select input picks the mask register or the flag register. Byte-lane enables allow access to the whole word or to either byte alone. Software can set and clear mask bits freely. Flag bits can only be cleared, and only through a handshake: software must read the flag as one and then write a zero to it. Any event on that buffer between the read and the write keeps the flag set, so no completion is lost.

Top module: `mbif_bank`

## Requirements
- R1: After reset the flag register and the mask register both read as zero, and `irq_o` is low.
- R2: A write with `sel_i`=0 updates the mask bits in the enabled lanes only (`be_i[0]` covers bits 7:0, `be_i[1]` covers bits 15:8). Mask bits in other lanes hold their value.
- R3: An event pulse on `evt_i[b]` sets flag bit b at that clock edge.
- R4: `req_o[b]` is flag b AND mask b. `irq_o` goes high one clock edge after any `req_o` bit is one, and goes low one edge after all are zero.
- R5: A flag bit clears at the edge of a zero-write to it (`sel_i`=1, lane enabled) when the most recent flag access to its lane was a read that returned one.
- R6: A zero-write to a flag bit that has not been read as one, for example because its lane was not enabled in the read, leaves the flag unchanged.
- R7: An event on a buffer between its read-as-one and the zero-write cancels the clear, and the flag stays set.
- R8: Writing a one to a flag bit never sets or clears it. Any flag write to an enabled lane uses up the earlier read, so a later zero-write without a new read has no effect.
- R9: When an event and a valid clear hit the same bit in the same cycle, the flag stays set.
- R10: While `rd_i` is high, `rdata_o` returns the selected register, with lanes that are not enabled reading as zero. While `rd_i` is low, `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Per-buffer completion pulses |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| sel_i | input | 1 | Register select: 0 selects mask, 1 selects flags |
| be_i | input | 2 | Byte-lane enables |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from the strobe |
| req_o | output | 16 | Per-buffer request, flag AND mask |
| irq_o | output | 1 | Registered OR of all requests |

## Verification
Read data is combinational, so the bench checks it one time step after driving the read strobe and before the clock edge. Flag, mask and `req_o` changes appear at the edge that samples the stimulus, so the bench checks those one step after that edge. `irq_o` carries one more register, so its rise and fall are checked at the first edge after the request changes, where it must still show the old value, and again at the following edge, where it must show the new one. Inputs change only on falling edges, so no check samples at the active edge.

// File: rtl/mbif_pkg.sv
package mbif_pkg;
   typedef enum logic {
      REG_MASK = 1'b0,
      REG_FLAG = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/mbif_lane_dec.sv
module mbif_lane_dec #(
   parameter int NBUF   = 16,
   parameter int LANE_W = 8,
   localparam int NLANE = NBUF / LANE_W
) (
   input  logic             rd_i,
   input  logic             wr_i,
   input  logic             sel_i,
   input  logic [NLANE-1:0] be_i,
   output logic [NBUF-1:0]  bit_en_o,
   output logic             flag_rd_o,
   output logic             flag_wr_o,
   output logic             mask_wr_o
);
   import mbif_pkg::*;

   if (NBUF % LANE_W != 0) begin : g_bad_split
      $error("mbif_lane_dec: NBUF must be a multiple of LANE_W");
   end

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      assign bit_en_o[l*LANE_W +: LANE_W] = {LANE_W{be_i[l]}};
   end

   always_comb begin
      flag_rd_o = rd_i && (sel_i == REG_FLAG);
      flag_wr_o = wr_i && (sel_i == REG_FLAG);
      mask_wr_o = wr_i && (sel_i == REG_MASK);
   end
endmodule

// File: rtl/mbif_flag_cell.sv
module mbif_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic rd_hit_i,
   input  logic wr_hit_i,
   input  logic wbit_i,
   output logic flag_o
);
   logic flag_q;
   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (evt_i)
            flag_q <= 1'b1;
         else if (wr_hit_i && arm_q && !wbit_i)
            flag_q <= 1'b0;

         if (evt_i || wr_hit_i)
            arm_q <= 1'b0;
         else if (rd_hit_i)
            arm_q <= flag_q;
      end
   end

   assign flag_o = flag_q;

   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_q); // R3
   AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(arm_q && wr_hit_i && !wbit_i && !evt_i)); // R5
   AST_ARM_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arm_q) |-> $past(rd_hit_i && flag_q && !wr_hit_i)); // R6
   AST_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !evt_i) |=> !flag_q); // R8
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i && wr_hit_i && arm_q && !wbit_i) |=> flag_q); // R9
endmodule

// File: rtl/mbif_mask_reg.sv
module mbif_mask_reg #(
   parameter int NBUF = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic [NBUF-1:0] bit_en_i,
   input  logic [NBUF-1:0] wdata_i,
   output logic [NBUF-1:0] mask_o
);
   logic [NBUF-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (wr_i)
         mask_q <= (mask_q & ~bit_en_i) | (wdata_i & bit_en_i);
   end

   assign mask_o = mask_q;

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_q)); // R2
   AST_MASK_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> ((mask_q & ~$past(bit_en_i)) == ($past(mask_q) & ~$past(bit_en_i)))); // R2
endmodule

// File: rtl/mbif_irq_comb.sv
module mbif_irq_comb #(
   parameter int NBUF    = 16,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NBUF-1:0] flag_i,
   input  logic [NBUF-1:0] mask_i,
   output logic [NBUF-1:0] req_o,
   output logic            irq_o
);
   logic any_req;

   assign req_o   = flag_i & mask_i;
   assign any_req = |req_o;

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_req;
      end
      assign irq_o = irq_q;

      AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
         any_req |=> irq_o); // R4
      AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
         !any_req |=> !irq_o); // R4
   end else begin : g_comb
      assign irq_o = any_req;
   end
endmodule

// File: rtl/mbif_bank.sv
module mbif_bank #(
   parameter int NBUF    = 16,
   parameter int LANE_W  = 8,
   parameter bit IRQ_REG = 1'b1,
   localparam int NLANE  = NBUF / LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBUF-1:0]  evt_i,
   input  logic             rd_i,
   input  logic             wr_i,
   input  logic             sel_i,
   input  logic [NLANE-1:0] be_i,
   input  logic [NBUF-1:0]  wdata_i,
   output logic [NBUF-1:0]  rdata_o,
   output logic [NBUF-1:0]  req_o,
   output logic             irq_o
);
   import mbif_pkg::*;

   if (NBUF < 1 || NBUF > 1024) begin : g_bad_nbuf
      $error("mbif_bank: NBUF out of range");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("mbif_bank: LANE_W must be positive");
   end

   logic [NBUF-1:0] bit_en;
   logic            flag_rd;
   logic            flag_wr;
   logic            mask_wr;
   logic [NBUF-1:0] flags;
   logic [NBUF-1:0] mask;

   mbif_lane_dec #(.NBUF(NBUF), .LANE_W(LANE_W)) u_dec (
      .rd_i      (rd_i),
      .wr_i      (wr_i),
      .sel_i     (sel_i),
      .be_i      (be_i),
      .bit_en_o  (bit_en),
      .flag_rd_o (flag_rd),
      .flag_wr_o (flag_wr),
      .mask_wr_o (mask_wr)
   );

   for (genvar b = 0; b < NBUF; b++) begin : g_flag
      mbif_flag_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt_i    (evt_i[b]),
         .rd_hit_i (flag_rd && bit_en[b]),
         .wr_hit_i (flag_wr && bit_en[b]),
         .wbit_i   (wdata_i[b]),
         .flag_o   (flags[b])
      );
   end

   mbif_mask_reg #(.NBUF(NBUF)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (mask_wr),
      .bit_en_i (bit_en),
      .wdata_i  (wdata_i),
      .mask_o   (mask)
   );

   mbif_irq_comb #(.NBUF(NBUF), .IRQ_REG(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (flags),
      .mask_i (mask),
      .req_o  (req_o),
      .irq_o  (irq_o)
   );

   always_comb begin
      if (!rd_i)
         rdata_o = '0;
      else if (sel_i == REG_FLAG)
         rdata_o = flags & bit_en;
      else
         rdata_o = mask & bit_en;
   end

   AST_RESET_ZERO: assert property (@(posedge clk)
      !rst_n |=> (flags == '0 && mask == '0)); // R1
   AST_REQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o & ~mask) == '0); // R4
endmodule

// File: tb/mbif_bank_tb.sv
module mbif_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] evt_i = '0;
   logic        rd_i = 1'b0;
   logic        wr_i = 1'b0;
   logic        sel_i = 1'b0;
   logic [1:0]  be_i = '0;
   logic [15:0] wdata_i = '0;
   logic [15:0] rdata_o;
   logic [15:0] req_o;
   logic        irq_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   mbif_bank u_dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_i(rd_i), .wr_i(wr_i),
      .sel_i(sel_i), .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .req_o(req_o), .irq_o(irq_o)
   );

   // {tag[3:0], evt[15:0], rd, wr, sel, be[1:0], wdata[15:0], exp[15:0]}
   // exp is rdata_o before the edge for reads, else req_o after the edge
   localparam int NVEC = 22;
   localparam logic [56:0] VEC [NVEC] = '{
      {4'd2,  16'h0000, 1'b0, 1'b1, 1'b0, 2'b11, 16'hFFFF, 16'h0000}, // R2 mask all on
      {4'd3,  16'h0005, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0005}, // R3
      {4'd10, 16'h0000, 1'b1, 1'b0, 1'b1, 2'b11, 16'h0000, 16'h0005}, // R10
      {4'd5,  16'h0000, 1'b0, 1'b1, 1'b1, 2'b11, 16'hFFFA, 16'h0000}, // R5
      {4'd3,  16'h8001, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h8001}, // R3
      {4'd6,  16'h0000, 1'b0, 1'b1, 1'b1, 2'b11, 16'h0000, 16'h8001}, // R6 unarmed
      {4'd10, 16'h0000, 1'b1, 1'b0, 1'b1, 2'b01, 16'h0000, 16'h0001}, // R10 low lane
      {4'd6,  16'h0000, 1'b0, 1'b1, 1'b1, 2'b11, 16'h0000, 16'h8000}, // R6 bit15 not read
      {4'd10, 16'h0000, 1'b1, 1'b0, 1'b1, 2'b11, 16'h0000, 16'h8000}, // R10
      {4'd7,  16'h8000, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h8000}, // R7 event between
      {4'd7,  16'h0000, 1'b0, 1'b1, 1'b1, 2'b11, 16'h0000, 16'h8000}, // R7
      {4'd10, 16'h0000, 1'b1, 1'b0, 1'b1, 2'b11, 16'h0000, 16'h8000}, // R10
      {4'd8,  16'h0000, 1'b0, 1'b1, 1'b1, 2'b11, 16'hFFFF, 16'h8000}, // R8 write ones
      {4'd8,  16'h0000, 1'b0, 1'b1, 1'b1, 2'b11, 16'h0000, 16'h8000}, // R8 arm used up
      {4'd10, 16'h0000, 1'b1, 1'b0, 1'b1, 2'b11, 16'h0000, 16'h8000}, // R10
      {4'd9,  16'h8000, 1'b0, 1'b1, 1'b1, 2'b11, 16'h0000, 16'h8000}, // R9 same cycle
      {4'd2,  16'h0000, 1'b0, 1'b1, 1'b0, 2'b10, 16'h0000, 16'h0000}, // R2 high lane off
      {4'd2,  16'h0000, 1'b1, 1'b0, 1'b0, 2'b11, 16'h0000, 16'h00FF}, // R2 readback
      {4'd4,  16'h0100, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0000}, // R4 masked
      {4'd4,  16'h0002, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0002}, // R4 enabled
      {4'd10, 16'h0000, 1'b1, 1'b0, 1'b1, 2'b10, 16'h0000, 16'h8100}, // R10 high lane
      {4'd6,  16'h0000, 1'b0, 1'b1, 1'b1, 2'b01, 16'h0000, 16'h0002}  // R6 lane not read
   };

   task automatic check(input bit ok, input string tag, input logic [15:0] act,
                        input logic [15:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [15:0] e, input logic r, input logic w,
                        input logic s, input logic [1:0] b, input logic [15:0] d);
      @(negedge clk);
      evt_i = e; rd_i = r; wr_i = w; sel_i = s; be_i = b; wdata_i = d;
   endtask

   task automatic idle();
      drive(16'h0, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0);
   endtask

   task automatic edge_wait();
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: reset state through the port
      drive(16'h0, 1'b1, 1'b0, 1'b0, 2'b11, 16'h0); #1;
      check(rdata_o == 16'h0, "R1 mask", rdata_o, 16'h0);
      drive(16'h0, 1'b1, 1'b0, 1'b1, 2'b11, 16'h0); #1;
      check(rdata_o == 16'h0, "R1 flags", rdata_o, 16'h0);
      check(irq_o == 1'b0, "R1 irq", {15'h0, irq_o}, 16'h0);
      edge_wait();

      for (int i = 0; i < NVEC; i++) begin
         logic [56:0] v;
         v = VEC[i];
         drive(v[52:37], v[36], v[35], v[34], v[33:32], v[31:16]);
         #1;
         if (v[36])
            check(rdata_o == v[15:0], $sformatf("R%0d vec%0d rdata", v[56:53], i),
                  rdata_o, v[15:0]);
         edge_wait();
         if (!v[36])
            check(req_o == v[15:0], $sformatf("R%0d vec%0d req", v[56:53], i),
                  req_o, v[15:0]);
      end
      idle(); #1;
      check(rdata_o == 16'h0, "R10 idle rdata", rdata_o, 16'h0);

      // R4: irq_o timing after a reset
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      drive(16'h0008, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0);
      edge_wait();
      edge_wait();
      check(irq_o == 1'b0, "R4 masked no irq", {15'h0, irq_o}, 16'h0);
      drive(16'h0, 1'b0, 1'b1, 1'b0, 2'b01, 16'h0008);
      edge_wait();
      check(req_o == 16'h0008, "R4 req after mask", req_o, 16'h0008);
      check(irq_o == 1'b0, "R4 irq one edge late", {15'h0, irq_o}, 16'h0);
      idle();
      edge_wait();
      check(irq_o == 1'b1, "R4 irq rise", {15'h0, irq_o}, 16'h1);
      drive(16'h0, 1'b1, 1'b0, 1'b1, 2'b01, 16'h0);
      edge_wait();
      drive(16'h0, 1'b0, 1'b1, 1'b1, 2'b01, 16'h0);
      edge_wait();
      check(req_o == 16'h0, "R5 cleared", req_o, 16'h0);
      check(irq_o == 1'b1, "R4 irq still high", {15'h0, irq_o}, 16'h1);
      idle();
      edge_wait();
      check(irq_o == 1'b0, "R4 irq fall", {15'h0, irq_o}, 16'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule